// File: doc/BRIEF.md
# Control-Pin Profile Selector

This block turns three external control pins into a complete set of per-channel clock-synthesizer controls. Each input combination picks one of eight stored profiles. A profile fixes, for each of four PLL channels, a spread-spectrum code, a choice between two stored divider sets, and a choice between two configured states for the channel's output pair. It also fixes a state choice for one stand-alone output. The profile table and all per-channel configuration arrive as static configuration vectors from the surrounding register file.

The pins are asynchronous. They pass through a two-flop synchronizer before they act as the profile index, and every decoded output is registered so that all channels switch in the same clock cycle. Two of the three pins can be shared with a serial bus. While `busMode` is high, those two pins read as zero, so only profiles 0 and 1 can be reached through the remaining pin. The spread code is also decoded into a magnitude in quarter-percent steps and a centre/down type flag, ready for a downstream modulator.

Top module: `ctl_profile_selector`

## Requirements
- R1: The index is {pin2, pin1, pin0}, where pin0 is ctlPin[0] and is the least significant bit. Profile p occupies profTable[p*21 +: 21]. Channel c's field sits at bits [c*5 +: 5] of the profile: [2:0] spread code, [3] divider-set select, [4] pair-state select. Bit 20 is the single-output state select. The spreadCode and freqSel outputs echo the selected fields.
- R2: A change on ctlPin is visible on the outputs after the third rising clock edge, and not after the second. All channels change in the same cycle.
- R3: For each channel, spreadMag gives the spread amount in units of 0.25 %. Codes 0 to 6 map to 0 to 6, and code 7 maps to 8 (2.0 %).
- R4: spreadDown[c] equals spreadDownCfg[c] (1 = down-spread, 0 = centre-spread), and is forced to 0 when the selected spread code is 000.
- R5: Output states use the encoding 00 power-down, 01 high-impedance, 10 driven low, 11 active. pairState[c] is stateCfg[c*4 +: 2] when the pair-state select is 0, and stateCfg[c*4+2 +: 2] when it is 1. The single output uses singleCfg[1:0] or singleCfg[3:2] in the same way. One select covers both outputs of a pair.
- R6: Divider set s of channel c is divSets[(c*2+s)*32 +: 32]. Bits [1:0] of the set are the VCO range code (00 below 125 MHz, 01 125–150, 10 150–175, 11 at or above 175 MHz) and bits [31:2] are the divider word. The divWord and vcoRange outputs carry the set that the divider-set select picks.
- R7: While busMode is 1, pin1 and pin2 are treated as 0, so the profile index is {0, 0, pin0}.
- R8: During reset, and after the first two rising edges following reset release, every output is 0. The selected profile first appears after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlPin | input | 3 | Asynchronous control pins, index bits |
| busMode | input | 1 | Pins 1 and 2 serve the serial bus |
| profTable | input | 168 | Eight 21-bit profiles |
| divSets | input | 256 | Two 32-bit divider sets per channel |
| stateCfg | input | 16 | Two 2-bit configured states per channel |
| singleCfg | input | 4 | Two 2-bit states for the single output |
| spreadDownCfg | input | 4 | Per-channel spread type, 1 = down |
| spreadCode | output | 12 | Selected 3-bit spread code per channel |
| spreadMag | output | 16 | Spread amount in 0.25 % units per channel |
| spreadDown | output | 4 | Down-spread flag per channel |
| freqSel | output | 4 | Selected divider set per channel |
| divWord | output | 120 | Selected 30-bit divider word per channel |
| vcoRange | output | 8 | Selected 2-bit VCO range per channel |
| pairState | output | 8 | 2-bit output-pair state per channel |
| singleState | output | 2 | State of the single output |

## Verification
All eight pin combinations are driven in turn against a profile table whose fields rotate across channels. This covers every spread code on some channel, both divider sets and both state selects, and shows whether index bits are swapped, fields are misplaced or a code is decoded wrongly. Sampling one cycle before and at the expected update cycle separates a correct two-stage synchronizer from a shorter or longer one. Repeating the upper pin patterns with bus mode on shows whether the two shared pins are really masked while pin0 still selects. Checks just after reset show the safe all-zero hold.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    ST_PWRDN  = 2'b00,
    ST_HIZ    = 2'b01,
    ST_LOW    = 2'b10,
    ST_ACTIVE = 2'b11
  } outState_e;

  typedef struct packed {
    logic [SEL_W-1:0] profIdx;
    logic             idxValid;
  } selStrobe_t;

  function automatic logic [3:0] spreadQuarters(input logic [2:0] code);
    return (code == 3'd7) ? 4'd8 : {1'b0, code};
  endfunction

endpackage

// File: rtl/pcs_pin_sync.sv
`timescale 1ns/1ps
module pcs_pin_sync
  import pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] ctlPin,
  input  logic             busMode,
  output selStrobe_t       strobe
);

  logic [SEL_W-1:0] metaQ;
  logic [SEL_W-1:0] syncQ;
  logic [1:0]       fillCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ   <= '0;
      syncQ   <= '0;
      fillCnt <= '0;
    end else begin
      metaQ <= ctlPin;
      syncQ <= metaQ;
      if (fillCnt != 2'd2) fillCnt <= fillCnt + 2'd1;
    end
  end

  always_comb begin
    strobe.profIdx = syncQ;
    if (busMode) strobe.profIdx[SEL_W-1:1] = '0;
    strobe.idxValid = (fillCnt == 2'd2);
  end

  // R2: pin0 reaches the index through exactly two flops
  a_r2_sync_depth: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idxValid |-> (strobe.profIdx[0] == $past(ctlPin[0], 2)));

endmodule

// File: rtl/pcs_profile_dp.sv
`timescale 1ns/1ps
module pcs_profile_dp
  import pcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 30
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  selStrobe_t                  strobe,
  input  logic [(1<<SEL_W)*(NUM_CH*5+1)-1:0] profTable,
  input  logic [NUM_CH*2*(DIV_W+2)-1:0] divSets,
  input  logic [NUM_CH*4-1:0]         stateCfg,
  input  logic [3:0]                  singleCfg,
  input  logic [NUM_CH-1:0]           spreadDownCfg,
  output logic [NUM_CH*3-1:0]         spreadCode,
  output logic [NUM_CH*4-1:0]         spreadMag,
  output logic [NUM_CH-1:0]           spreadDown,
  output logic [NUM_CH-1:0]           freqSel,
  output logic [NUM_CH*DIV_W-1:0]     divWord,
  output logic [NUM_CH*2-1:0]         vcoRange,
  output logic [NUM_CH*2-1:0]         pairState,
  output logic [1:0]                  singleState
);

  localparam int CH_F   = 5;
  localparam int PROF_W = NUM_CH*CH_F + 1;
  localparam int SET_W  = DIV_W + 2;

  logic [PROF_W-1:0] curProf;
  assign curProf = profTable[strobe.profIdx*PROF_W +: PROF_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0]       codeD;
    logic             fselD;
    logic             sselD;
    logic [SET_W-1:0] setD;
    logic [1:0]       stateD;

    always_comb begin
      codeD  = curProf[c*CH_F +: 3];
      fselD  = curProf[c*CH_F + 3];
      sselD  = curProf[c*CH_F + 4];
      setD   = fselD ? divSets[(c*2+1)*SET_W +: SET_W]
                     : divSets[(c*2)*SET_W +: SET_W];
      stateD = sselD ? stateCfg[c*4+2 +: 2] : stateCfg[c*4 +: 2];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        spreadCode[c*3 +: 3]      <= '0;
        spreadMag[c*4 +: 4]       <= '0;
        spreadDown[c]             <= 1'b0;
        freqSel[c]                <= 1'b0;
        divWord[c*DIV_W +: DIV_W] <= '0;
        vcoRange[c*2 +: 2]        <= '0;
        pairState[c*2 +: 2]       <= ST_PWRDN;
      end else if (strobe.idxValid) begin
        spreadCode[c*3 +: 3]      <= codeD;
        spreadMag[c*4 +: 4]       <= spreadQuarters(codeD);
        spreadDown[c]             <= spreadDownCfg[c] && (codeD != 3'd0);
        freqSel[c]                <= fselD;
        divWord[c*DIV_W +: DIV_W] <= setD[SET_W-1:2];
        vcoRange[c*2 +: 2]        <= setD[1:0];
        pairState[c*2 +: 2]       <= stateD;
      end
    end

    // R3: magnitude is never the unused value 7 nor above 2.0 %
    a_r3_mag_legal: assert property (@(posedge clk) disable iff (!rstN)
      (spreadMag[c*4 +: 4] != 4'd7) && (spreadMag[c*4 +: 4] <= 4'd8));

    // R5: a pair's state is one of its two configured states
    a_r5_pair_state_legal: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.idxValid) |->
        (pairState[c*2 +: 2] == $past(stateCfg[c*4 +: 2])) ||
        (pairState[c*2 +: 2] == $past(stateCfg[c*4+2 +: 2])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                singleState <= ST_PWRDN;
    else if (strobe.idxValid) singleState <= curProf[PROF_W-1] ? singleCfg[3:2]
                                                               : singleCfg[1:0];
  end

  // R8: nothing but zeros leaves the block before the index is valid
  a_r8_safe_until_valid: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.idxValid) |-> (spreadCode == '0) && (freqSel == '0) &&
      (pairState == '0) && (singleState == '0) && (divWord == '0));

  // R2: steady index and configuration leave every output steady
  a_r2_switch_together: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.idxValid) && strobe.idxValid && $stable(strobe.profIdx) &&
     $stable(profTable) && $stable(divSets) && $stable(stateCfg) &&
     $stable(singleCfg) && $stable(spreadDownCfg))
    |=> ($stable(spreadCode) && $stable(divWord) && $stable(pairState) &&
         $stable(singleState) && $stable(spreadDown)));

endmodule

// File: rtl/ctl_profile_selector.sv
`timescale 1ns/1ps
module ctl_profile_selector
  import pcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 30
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SEL_W-1:0]            ctlPin,
  input  logic                        busMode,
  input  logic [(1<<SEL_W)*(NUM_CH*5+1)-1:0] profTable,
  input  logic [NUM_CH*2*(DIV_W+2)-1:0] divSets,
  input  logic [NUM_CH*4-1:0]         stateCfg,
  input  logic [3:0]                  singleCfg,
  input  logic [NUM_CH-1:0]           spreadDownCfg,
  output logic [NUM_CH*3-1:0]         spreadCode,
  output logic [NUM_CH*4-1:0]         spreadMag,
  output logic [NUM_CH-1:0]           spreadDown,
  output logic [NUM_CH-1:0]           freqSel,
  output logic [NUM_CH*DIV_W-1:0]     divWord,
  output logic [NUM_CH*2-1:0]         vcoRange,
  output logic [NUM_CH*2-1:0]         pairState,
  output logic [1:0]                  singleState
);

  selStrobe_t strobe;

  pcs_pin_sync u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .ctlPin  (ctlPin),
    .busMode (busMode),
    .strobe  (strobe)
  );

  pcs_profile_dp #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .profTable     (profTable),
    .divSets       (divSets),
    .stateCfg      (stateCfg),
    .singleCfg     (singleCfg),
    .spreadDownCfg (spreadDownCfg),
    .spreadCode    (spreadCode),
    .spreadMag     (spreadMag),
    .spreadDown    (spreadDown),
    .freqSel       (freqSel),
    .divWord       (divWord),
    .vcoRange      (vcoRange),
    .pairState     (pairState),
    .singleState   (singleState)
  );

endmodule

// File: tb/ctl_profile_selector_bench.sv
`timescale 1ns/1ps
module ctl_profile_selector_bench;

  localparam int NCH    = 4;
  localparam int DW     = 30;
  localparam int PW     = NCH*5 + 1;
  localparam int SW     = DW + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        ctlPin = 3'd0;
  logic              busMode = 1'b0;
  logic [8*PW-1:0]   profTable;
  logic [NCH*2*SW-1:0] divSets;
  logic [NCH*4-1:0]  stateCfg;
  logic [3:0]        singleCfg;
  logic [NCH-1:0]    spreadDownCfg;
  logic [NCH*3-1:0]  spreadCode;
  logic [NCH*4-1:0]  spreadMag;
  logic [NCH-1:0]    spreadDown;
  logic [NCH-1:0]    freqSel;
  logic [NCH*DW-1:0] divWord;
  logic [NCH*2-1:0]  vcoRange;
  logic [NCH*2-1:0]  pairState;
  logic [1:0]        singleState;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ctl_profile_selector u_ctl_profile_selector (
    .clk(clk), .rstN(rstN), .ctlPin(ctlPin), .busMode(busMode),
    .profTable(profTable), .divSets(divSets), .stateCfg(stateCfg),
    .singleCfg(singleCfg), .spreadDownCfg(spreadDownCfg),
    .spreadCode(spreadCode), .spreadMag(spreadMag), .spreadDown(spreadDown),
    .freqSel(freqSel), .divWord(divWord), .vcoRange(vcoRange),
    .pairState(pairState), .singleState(singleState)
  );

  logic [NCH*3-1:0]  eCode;
  logic [NCH*4-1:0]  eMag;
  logic [NCH-1:0]    eDown;
  logic [NCH-1:0]    eFsel;
  logic [NCH*DW-1:0] eDiv;
  logic [NCH*2-1:0]  eRange;
  logic [NCH*2-1:0]  ePair;
  logic [1:0]        eSingle;

  task automatic check(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic computeExp(input int idx);
    logic [4:0] f;
    logic [SW-1:0] s;
    for (int c = 0; c < NCH; c++) begin
      f = profTable[idx*PW + c*5 +: 5];
      eCode[c*3 +: 3] = f[2:0];
      eMag[c*4 +: 4]  = (f[2:0] == 3'd7) ? 4'd8 : {1'b0, f[2:0]};
      eDown[c]        = (f[2:0] == 3'd0) ? 1'b0 : spreadDownCfg[c];
      eFsel[c]        = f[3];
      s               = divSets[(c*2 + int'(f[3]))*SW +: SW];
      eDiv[c*DW +: DW] = s[SW-1:2];
      eRange[c*2 +: 2] = s[1:0];
      ePair[c*2 +: 2]  = stateCfg[c*4 + (f[4] ? 2 : 0) +: 2];
    end
    eSingle = profTable[idx*PW + PW-1] ? singleCfg[3:2] : singleCfg[1:0];
  endtask

  task automatic checkAll(input string req);
    check(req, "R1 spreadCode", 128'(spreadCode), 128'(eCode));
    check(req, "R3 spreadMag",  128'(spreadMag),  128'(eMag));
    check(req, "R4 spreadDown", 128'(spreadDown), 128'(eDown));
    check(req, "R6 freqSel",    128'(freqSel),    128'(eFsel));
    check(req, "R6 divWord",    128'(divWord),    128'(eDiv));
    check(req, "R6 vcoRange",   128'(vcoRange),   128'(eRange));
    check(req, "R5 pairState",  128'(pairState),  128'(ePair));
    check(req, "R5 singleState",128'(singleState),128'(eSingle));
  endtask

  task automatic checkZero(input string req);
    check(req, "zero code",  128'(spreadCode), 128'(0));
    check(req, "zero state", 128'({pairState, singleState}), 128'(0));
    check(req, "zero div",   128'(divWord), 128'(0));
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadConfig();
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < NCH; c++) begin
        profTable[p*PW + c*5 +: 3] = 3'((p + c) % 8);
        profTable[p*PW + c*5 + 3]  = 1'((p >> (c % 3)) & 1);
        profTable[p*PW + c*5 + 4]  = 1'(((p + c) >> 1) & 1);
      end
      profTable[p*PW + PW-1] = 1'((p ^ (p >> 2)) & 1);
    end
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 2; s++)
        divSets[(c*2+s)*SW +: SW] = {30'(32'h1000*(c+1) + s*7 + c), 2'((c + s) % 4)};
    for (int c = 0; c < NCH; c++) begin
      stateCfg[c*4 +: 2]   = 2'(c % 4);
      stateCfg[c*4+2 +: 2] = 2'((c + 2) % 4);
    end
    singleCfg     = 4'b11_01;
    spreadDownCfg = 4'b0101;
  endtask

  // R8: safe zeros for two edges after reset release, profile on the third
  task automatic t_reset();
    ctlPin = 3'd5;
    #1;
    checkZero("R8 in reset");
    @(negedge clk); rstN = 1'b1;
    waitEdges(1); checkZero("R8 edge1");
    waitEdges(1); checkZero("R8 edge2");
    waitEdges(1); computeExp(5); checkAll("R8 edge3 profile5");
  endtask

  // R1 R3 R4 R5 R6: every pin pattern, bus mode off
  task automatic t_sweep();
    busMode = 1'b0;
    for (int p = 0; p < 8; p++) begin
      ctlPin = 3'(p);
      waitEdges(3);
      computeExp(p);
      checkAll($sformatf("R1 sweep idx%0d", p));
    end
  endtask

  // R2: unchanged after two edges, updated after three
  task automatic t_latency();
    busMode = 1'b0;
    ctlPin = 3'd2; waitEdges(3);
    ctlPin = 3'd5;
    waitEdges(2); computeExp(2); checkAll("R2 still old after 2 edges");
    waitEdges(1); computeExp(5); checkAll("R2 new after 3 edges");
  endtask

  // R7: bus mode masks pin1 and pin2
  task automatic t_bus();
    busMode = 1'b1;
    ctlPin = 3'd7; waitEdges(3); computeExp(1); checkAll("R7 pins7 -> profile1");
    ctlPin = 3'd6; waitEdges(3); computeExp(0); checkAll("R7 pins6 -> profile0");
    ctlPin = 3'd3; waitEdges(3); computeExp(1); checkAll("R7 pins3 -> profile1");
    busMode = 1'b0; waitEdges(3); computeExp(3); checkAll("R7 bus off -> profile3");
  endtask

  // R4: down flag follows the configuration change
  task automatic t_spreadType();
    spreadDownCfg = 4'b1010;
    ctlPin = 3'd4; waitEdges(3); computeExp(4); checkAll("R4 down cfg 1010");
  endtask

  initial begin
    loadConfig();
    t_reset();
    t_sweep();
    t_latency();
    t_bus();
    t_spreadType();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule